// File: doc/BRIEF.md
# Late-Write Synchronous SRAM with Read Coherency

This block is a synchronous single-port memory built so that reads and writes can alternate on every clock with no idle cycles between them. The kind of access is decided only on a load cycle, which is a cycle with `advance` low. On that edge the block registers the address, the chip selects, the read/write choice and the byte-lane enables. A read returns its data flow-through, in the cycle right after the edge that registered its address. A write takes its data one edge later. That write data waits in a pending register and goes into the storage array when the next write data arrives.

A read whose address matches the pending write returns a merged word. The bytes enabled in the pending write come from the pending register and the other bytes come from the array, so the read sees the newest data. A cycle with `advance` high continues a four-beat burst. It keeps the access type chosen at the load, steps a two-bit counter, and forms the low address bits either linearly or by exclusive-or with the counter. A high `hold` makes the block ignore the edge, so the whole state freezes. The read port is a data word with a valid flag, and the flag drops during writes, deselects and quiet reads.

Top module: `lw_sram`

## Requirements
- R1: While reset is applied, and after it is released, the block is deselected and `rvalid` is 0 until a read is loaded.
- R2: On a load edge (`advance`=0) with all selects active, `rd_wr`=1 starts a read and `rd_wr`=0 starts a write. On a continue edge (`advance`=1), `rd_wr` is ignored and the burst keeps the type chosen at its load.
- R3: On a load edge the selects are active only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. Otherwise the cycle is a deselect: `rvalid` is 0 and nothing is written. Continue edges after a deselect stay deselected.
- R4: A read is flow-through. After the edge that registers the read address, in that same clock cycle, `rvalid`=1 and `rdata` holds the word at the read address. `rdata` is 0 whenever `rvalid` is 0.
- R5: Write data is taken from `wdata` at the first non-held edge after the edge that registered the write address. Bit i of `lane_we_n` is registered with the address and is active low. It enables the byte `wdata[8*i+7:8*i]`.
- R6: A write beat, load or continue, whose `lane_we_n` is 4'b1111 writes nothing.
- R7: A read always returns the most recent data. This includes a write issued on the edge just before the read, whose data is still pending, and only that write's enabled bytes replace the older bytes.
- R8: Continue edges step a two-bit beat counter n that wraps after four beats, and the upper address bits stay fixed. With `burst_linear`=1 the low two bits are (base+n) mod 4. With `burst_linear`=0 they are base XOR n.
- R9: An edge with `hold`=1 is ignored. The access type, the burst position and the pending write are unchanged, no write is performed, and a read in progress keeps `rvalid` and `rdata` unchanged.
- R10: Each beat of a write burst uses the `lane_we_n` value registered on that beat's own edge.
- R11: While `show_rd`=0, a read still advances normally but `rvalid` is 0. `show_rd` acts without any clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hold | input | 1 | 1 = ignore this edge (stall) |
| advance | input | 1 | 0 = load a new address and command, 1 = continue the burst |
| rd_wr | input | 1 | Access type on load edges: 1 = read, 0 = write |
| sel_a_n | input | 1 | Active-low chip select |
| sel_b_n | input | 1 | Active-low chip select |
| sel_c | input | 1 | Active-high chip select |
| burst_linear | input | 1 | Burst order: 1 = linear, 0 = interleaved |
| show_rd | input | 1 | Read output enable for the valid flag |
| addr | input | ADDR_W | Word address sampled on load edges |
| lane_we_n | input | LANES | Active-low byte-lane write enables, sampled every edge |
| wdata | input | LANES*LANE_W | Write data, one edge after its address |
| rdata | output | LANES*LANE_W | Flow-through read data |
| rvalid | output | 1 | rdata carries a valid read word |

## Verification
A read result is due in the same cycle as the edge that registered its address. The bench therefore drives every command on a falling edge and checks `rvalid` and `rdata` on the following falling edge, after exactly one rising edge. Write data is applied to the bench's memory model at the first non-held edge after the write's address edge. Any later read, including the read issued on that very edge, is compared with that model. Held edges leave the model untouched, so each stalled cycle is checked again against the value expected before the stall, and the quiet-read flag is checked within the cycle after `show_rd` changes, with no edge in between.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

  // Access type held between a load edge and the next load edge
  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_RD   = 2'd1,
    CYC_WR   = 2'd2
  } cyc_e;

endpackage

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              advance,
  input  logic              rd_wr,
  input  logic              sel_a_n,
  input  logic              sel_b_n,
  input  logic              sel_c,
  input  logic              burst_linear,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_we_n,
  output cyc_e              cyc_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [LANES-1:0]  cur_mask_n_o
);

  localparam int HI_W = ADDR_W - BURST_W;

  cyc_e               cyc_q, cyc_d;
  logic [ADDR_W-1:0]  base_q, base_d;
  logic [BURST_W-1:0] cnt_q, cnt_d;
  logic [LANES-1:0]   mask_n_q;
  logic               selected;
  logic               step_en;
  logic [BURST_W-1:0] base_lo;
  logic [BURST_W-1:0] beat_lo;

  assign selected = !sel_a_n && !sel_b_n && sel_c;
  assign step_en  = !hold;

  // next-state decode: type fixed only on load edges
  always_comb begin
    cyc_d  = cyc_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    if (!advance) begin
      base_d = addr;
      cnt_d  = '0;
      if (selected) cyc_d = rd_wr ? CYC_RD : CYC_WR;
      else          cyc_d = CYC_IDLE;
    end else if (cyc_q != CYC_IDLE) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q    <= CYC_IDLE;
      base_q   <= '0;
      cnt_q    <= '0;
      mask_n_q <= '1;
    end else if (step_en) begin
      cyc_q    <= cyc_d;
      base_q   <= base_d;
      cnt_q    <= cnt_d;
      mask_n_q <= lane_we_n;
    end
  end

  // beat address: linear adds, interleaved flips bits of the base
  assign base_lo = base_q[BURST_W-1:0];
  always_comb begin
    if (burst_linear) beat_lo = base_lo + cnt_q;
    else              beat_lo = base_lo ^ cnt_q;
  end

  generate
    if (HI_W > 0) begin : g_hi
      assign cur_addr_o = {base_q[ADDR_W-1:BURST_W], beat_lo};
    end else begin : g_nohi
      assign cur_addr_o = beat_lo;
    end
  endgenerate

  assign cyc_o        = cyc_q;
  assign cur_mask_n_o = mask_n_q;

  // R9: an ignored edge freezes type and burst position
  a_r9_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(cyc_q) && $stable(base_q) && $stable(cnt_q)));

  // R3: continue edges never leave the deselected state
  a_r3_idle_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && advance && cyc_q == CYC_IDLE) |=> (cyc_q == CYC_IDLE));

  // R2: continue edges keep the type from the load edge
  a_r2_type_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && advance && cyc_q != CYC_IDLE) |=> (cyc_q == $past(cyc_q)));

  // R8: each continue edge moves the beat counter by one
  a_r8_beat_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && advance && cyc_q != CYC_IDLE) |=>
      (cnt_q == BURST_W'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/lw_sram_wpend.sv
module lw_sram_wpend
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hold,
  input  cyc_e                    cyc,
  input  logic [ADDR_W-1:0]       cur_addr,
  input  logic [LANES-1:0]        cur_mask_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES*LANE_W-1:0] arr_word,
  output logic                    commit_en,
  output logic [ADDR_W-1:0]       commit_addr,
  output logic [LANES-1:0]        commit_lanes,
  output logic [LANES*LANE_W-1:0] commit_data,
  output logic [LANES*LANE_W-1:0] rd_word
);

  localparam int DATA_W = LANES * LANE_W;

  logic              pend_v_q, pend_v_d;
  logic [ADDR_W-1:0] pend_addr_q, pend_addr_d;
  logic [LANES-1:0]  pend_lanes_q, pend_lanes_d;
  logic [DATA_W-1:0] pend_data_q, pend_data_d;
  logic              capture;
  logic              hit;

  // late data arrives on the first live edge of the cycle after a write beat
  assign capture = !hold && (cyc == CYC_WR);

  always_comb begin
    pend_v_d     = pend_v_q;
    pend_addr_d  = pend_addr_q;
    pend_lanes_d = pend_lanes_q;
    pend_data_d  = pend_data_q;
    if (capture) begin
      pend_v_d     = |(~cur_mask_n);
      pend_addr_d  = cur_addr;
      pend_lanes_d = ~cur_mask_n;
      pend_data_d  = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q     <= 1'b0;
      pend_addr_q  <= '0;
      pend_lanes_q <= '0;
      pend_data_q  <= '0;
    end else if (capture) begin
      pend_v_q     <= pend_v_d;
      pend_addr_q  <= pend_addr_d;
      pend_lanes_q <= pend_lanes_d;
      pend_data_q  <= pend_data_d;
    end
  end

  // older pending write retires when it is replaced
  assign commit_en    = capture && pend_v_q;
  assign commit_addr  = pend_addr_q;
  assign commit_lanes = pend_lanes_q;
  assign commit_data  = pend_data_q;

  // forwarding merge, lane by lane
  assign hit = pend_v_q && (pend_addr_q == cur_addr);

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_fwd
      assign rd_word[i*LANE_W +: LANE_W] = (hit && pend_lanes_q[i]) ?
        pend_data_q[i*LANE_W +: LANE_W] : arr_word[i*LANE_W +: LANE_W];
    end
  endgenerate

  // R6: an all-disabled write beat leaves nothing pending
  a_r6_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && (&cur_mask_n)) |=> !pend_v_q);

  // R9: the pending write is untouched on ignored edges
  a_r9_pending_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(pend_v_q) && $stable(pend_addr_q) &&
              $stable(pend_lanes_q) && $stable(pend_data_q)));

  // R5: nothing retires to the array outside a write data edge
  a_r5_commit_on_data: assert property (@(posedge clk) disable iff (!rst_n)
    (hold || cyc != CYC_WR) |=> ($stable(pend_data_q) && $stable(pend_addr_q)));

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int i = 0; i < LANES; i++) begin
        if (wr_lanes[i]) mem_q[wr_addr][i*LANE_W +: LANE_W] <= wr_data[i*LANE_W +: LANE_W];
      end
    end
  end

  // asynchronous read gives the flow-through timing
  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int LANE_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hold,
  input  logic                    advance,
  input  logic                    rd_wr,
  input  logic                    sel_a_n,
  input  logic                    sel_b_n,
  input  logic                    sel_c,
  input  logic                    burst_linear,
  input  logic                    show_rd,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);

  localparam int DATA_W = LANES * LANE_W;

  logic              rst_meta_q, rst_q;
  cyc_e              cyc;
  logic [ADDR_W-1:0] cur_addr;
  logic [LANES-1:0]  cur_mask_n;
  logic [DATA_W-1:0] arr_word;
  logic [DATA_W-1:0] rd_word;
  logic              commit_en;
  logic [ADDR_W-1:0] commit_addr;
  logic [LANES-1:0]  commit_lanes;
  logic [DATA_W-1:0] commit_data;

  // reset asserts at once, leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  lw_sram_ctrl #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .BURST_W(BURST_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_q),
    .hold        (hold),
    .advance     (advance),
    .rd_wr       (rd_wr),
    .sel_a_n     (sel_a_n),
    .sel_b_n     (sel_b_n),
    .sel_c       (sel_c),
    .burst_linear(burst_linear),
    .addr        (addr),
    .lane_we_n   (lane_we_n),
    .cyc_o       (cyc),
    .cur_addr_o  (cur_addr),
    .cur_mask_n_o(cur_mask_n)
  );

  lw_sram_wpend #(
    .ADDR_W(ADDR_W),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) u_wpend (
    .clk         (clk),
    .rst_n       (rst_q),
    .hold        (hold),
    .cyc         (cyc),
    .cur_addr    (cur_addr),
    .cur_mask_n  (cur_mask_n),
    .wdata       (wdata),
    .arr_word    (arr_word),
    .commit_en   (commit_en),
    .commit_addr (commit_addr),
    .commit_lanes(commit_lanes),
    .commit_data (commit_data),
    .rd_word     (rd_word)
  );

  lw_sram_array #(
    .ADDR_W(ADDR_W),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) u_array (
    .clk     (clk),
    .wr_en   (commit_en),
    .wr_addr (commit_addr),
    .wr_lanes(commit_lanes),
    .wr_data (commit_data),
    .rd_addr (cur_addr),
    .rd_data (arr_word)
  );

  assign rvalid = (cyc == CYC_RD) && show_rd;
  assign rdata  = rvalid ? rd_word : '0;

  // R9: a read stalled by hold keeps presenting the same word
  a_r9_read_holds: assert property (@(posedge clk) disable iff (!rst_q)
    (hold && cyc == CYC_RD) |=> $stable(rd_word));

  // R4: no valid read data appears during the cycle after a write beat edge
  a_r4_no_read_after_wr: assert property (@(posedge clk) disable iff (!rst_q)
    (!hold && !advance && !rd_wr) |=> !rvalid);

endmodule

// File: tb/lw_sram_bench.sv
module lw_sram_bench;

  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LW = 8;
  localparam int DW = LN * LW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          hold, advance, rd_wr, sel_a_n, sel_b_n, sel_c;
  logic          burst_linear, show_rd;
  logic [AW-1:0] addr;
  logic [LN-1:0] lane_we_n;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          rvalid;

  always #5 clk = ~clk;

  lw_sram u_lw_sram (
    .clk(clk), .rst_n(rst_n), .hold(hold), .advance(advance), .rd_wr(rd_wr),
    .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
    .burst_linear(burst_linear), .show_rd(show_rd), .addr(addr),
    .lane_we_n(lane_we_n), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state, kept from the requirements
  logic [DW-1:0] ref_mem [1 << AW];
  int            m_cyc;   // 0 idle, 1 read, 2 write
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  logic [LN-1:0] m_mask;
  logic [DW-1:0] owed;

  task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] m_addr();
    logic [1:0] lo;
    lo = burst_linear ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
    return {m_base[AW-1:2], lo};
  endfunction

  function automatic logic [DW-1:0] fdat(int a, int salt);
    return (DW'(a) + DW'(salt) * 32'h0101_0107) * 32'h9E37_79B1;
  endfunction

  task automatic verify(string tag);
    if (m_cyc == 1 && show_rd) begin
      check(tag, "rvalid", DW'(rvalid), DW'(1));
      check(tag, "rdata", rdata, ref_mem[m_addr()]);
    end else begin
      check(tag, "rvalid", DW'(rvalid), DW'(0));
      check(tag, "rdata idle", rdata, '0);
    end
  endtask

  // one clock: drive on the falling edge, update model at rising edge, check next fall
  task automatic step(string tag, bit adv, bit rw, bit [2:0] sel, bit [3:0] we_n,
                      int a, logic [DW-1:0] d, bit hld = 1'b0);
    advance = adv; rd_wr = rw; {sel_a_n, sel_b_n, sel_c} = sel;
    lane_we_n = we_n; addr = AW'(a); hold = hld;
    wdata = hld ? ~owed : owed;
    @(posedge clk);
    if (!hld) begin
      if (m_cyc == 2) begin
        for (int i = 0; i < LN; i++)
          if (!m_mask[i]) ref_mem[m_addr()][i*LW +: LW] = owed[i*LW +: LW];
      end
      if (!adv) begin
        m_base = AW'(a); m_cnt = 2'd0;
        m_cyc = (sel == 3'b001) ? (rw ? 1 : 2) : 0;
      end else if (m_cyc != 0) begin
        m_cnt = m_cnt + 2'd1;
      end
      m_mask = we_n;
      owed = d;
    end
    @(negedge clk);
    verify(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hold = 0; advance = 1; rd_wr = 1;
    sel_a_n = 1; sel_b_n = 0; sel_c = 1; burst_linear = 1; show_rd = 1;
    addr = '0; lane_we_n = '1; wdata = '0;
    m_cyc = 0; m_base = '0; m_cnt = '0; m_mask = '1; owed = '0;
    repeat (3) @(negedge clk);
    check("R1", "rvalid in reset", DW'(rvalid), DW'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "rvalid after reset", DW'(rvalid), DW'(0));
    check("R1", "rdata after reset", rdata, '0);

    // R5: fill every word with back-to-back full writes
    for (int a = 0; a < (1 << AW); a++) step("R5", 0, 0, 3'b001, 4'b0000, a, fdat(a, 1));
    // R4: read everything back, flow-through
    for (int a = 0; a < (1 << AW); a++) step("R4", 0, 1, 3'b001, 4'b0000, a, '0);

    // R7: read right behind a write to the same word, full and partial
    for (int a = 0; a < (1 << AW); a += 5) begin
      step("R7", 0, 0, 3'b001, 4'b0000, a, fdat(a, 2));
      step("R7", 0, 1, 3'b001, 4'b1111, a, '0);
      step("R7", 0, 0, 3'b001, 4'(a), a, fdat(a, 3));
      step("R7", 0, 0, 3'b001, 4'(~a), a, fdat(a, 4));
      step("R7", 0, 1, 3'b001, 4'b0000, a, '0);
    end

    // R5/R6: every byte-enable pattern on one word
    for (int m = 0; m < 16; m++) begin
      step((m == 15) ? "R6" : "R5", 0, 0, 3'b001, 4'(m), 9, fdat(m, 5));
      step((m == 15) ? "R6" : "R5", 0, 1, 3'b001, 4'b0000, 9, '0);
    end

    // R8/R2: read bursts in both orders from each start, rd_wr flipped on continues
    for (int lin = 0; lin < 2; lin++) begin
      for (int b = 0; b < 4; b++) begin
        burst_linear = lin[0];
        step("R8", 0, 1, 3'b001, 4'b0000, 20 + b, '0);
        for (int k = 0; k < 4; k++) step("R2", 1, 0, 3'b001, 4'b0000, 7, '0);
        step("R8", 0, 0, 3'b001, 4'b1111, 0, '0);
      end
    end

    // R10/R6: write bursts with per-beat enables, then read back as a burst
    for (int lin = 0; lin < 2; lin++) begin
      burst_linear = lin[0];
      step("R10", 0, 0, 3'b001, 4'b0000, 33, fdat(lin, 6));
      step("R10", 1, 1, 3'b001, 4'b1110, 0, fdat(lin, 7));
      step("R6",  1, 1, 3'b001, 4'b1111, 0, fdat(lin, 8));
      step("R10", 1, 1, 3'b001, 4'b0110, 0, fdat(lin, 9));
      step("R10", 1, 1, 3'b001, 4'b0001, 0, fdat(lin, 10));
      step("R10", 0, 1, 3'b001, 4'b0000, 33, '0);
      for (int k = 0; k < 3; k++) step("R10", 1, 1, 3'b001, 4'b0000, 0, '0);
    end

    // R3: each inactive select, then continues stay deselected
    for (int s = 0; s < 8; s++) begin
      if (s != 1) begin
        step("R3", 0, 0, 3'(s), 4'b0000, 40, fdat(s, 11));
        step("R3", 1, 1, 3'(s), 4'b0000, 40, fdat(s, 12));
        step("R3", 1, 0, 3'b001, 4'b0000, 40, fdat(s, 13));
        step("R3", 0, 1, 3'b001, 4'b0000, 40, '0);
      end
    end

    // R9: stalls during a read, a write data phase and a burst
    step("R9", 0, 1, 3'b001, 4'b0000, 12, '0);
    for (int k = 0; k < 3; k++) step("R9", 0, 0, 3'b001, 4'b0000, 50 + k, fdat(k, 14), 1'b1);
    step("R9", 0, 0, 3'b001, 4'b0101, 13, fdat(13, 15));
    step("R9", 1, 0, 3'b001, 4'b0000, 0, '0, 1'b1);
    step("R9", 0, 0, 3'b000, 4'b0000, 0, '0, 1'b1);
    step("R9", 0, 1, 3'b001, 4'b0000, 13, '0);
    burst_linear = 1'b0;
    step("R9", 0, 1, 3'b001, 4'b0000, 46, '0);
    step("R9", 1, 1, 3'b001, 4'b0000, 0, '0);
    step("R9", 1, 1, 3'b001, 4'b0000, 0, '0, 1'b1);
    step("R9", 1, 1, 3'b001, 4'b0000, 0, '0);
    step("R9", 1, 1, 3'b001, 4'b0000, 0, '0);

    // R11: quiet read acts at once
    step("R11", 0, 1, 3'b001, 4'b0000, 12, '0);
    show_rd = 1'b0;
    #1;
    check("R11", "rvalid quiet", DW'(rvalid), DW'(0));
    step("R11", 1, 1, 3'b001, 4'b0000, 0, '0);
    show_rd = 1'b1;
    #1;
    check("R11", "rvalid shown", DW'(rvalid), DW'(1));
    check("R11", "rdata shown", rdata, ref_mem[m_addr()]);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule